// File: doc/BRIEF.md
# Blanking-Level Video Clamp

This block sits on an 8-bit digitized composite video stream and removes the offset of the blanking level. On every line it averages a fixed, power-of-two number of samples taken while the back porch window flag is set. It latches that average as the line's blanking level when the next line-start marker arrives. While correction is enabled, each sample is shifted so that this measured level comes out on a fixed code: 3Ch for the 525-line standard and 40h for the 625-line standard. Values below blanking are rescaled so that the sync tip comes out on a programmable code. The measured level is also exported as a plain status value.

Samples enter and leave through valid/ready streams. The output has a single register stage. The input is ready whenever that stage is empty or is being drained in the same cycle. A stalled output holds its data and valid until ready returns. The back porch flag and the line-start marker travel as sideband bits with each input sample, and only accepted samples count. The standard select, enable and sync tip code are plain levels, sampled when a sample is accepted.

Top module: `vid_blank_clamp`

## Requirements
- R1: The input is ready exactly when the output holds no data or the output is ready. Each accepted sample appears on the output one clock later, in order. While the output is valid and not ready, the output stays valid and its data does not change.
- R2: With clamp_en low, the output sample equals the input sample.
- R3: With clamp_en high and the input above the measured level L, the output is min(FFh, input − L + B). B is 3Ch when std_pal is 0 and 40h when std_pal is 1.
- R4: With clamp_en high and the input equal to L, the output is exactly B.
- R5: With clamp_en high and the input below L, the output is max(0, B − floor((L − input) × (B − T) / 57)). T is tip_lvl when std_pal is 0, and tip_lvl + 4 when std_pal is 1.
- R6: With tip_lvl at 3 and an input 57 codes below L, the output is 03h for std_pal 0 and 07h for std_pal 1.
- R7: blank_lvl becomes floor(sum / 16) of the first 16 back-porch samples accepted since the previous line-start. Back-porch samples beyond the first 16 in a line are ignored. The update happens on the clock that accepts a sample with s_sol set.
- R8: A line that delivers fewer than 16 back-porch samples before the next line-start leaves blank_lvl unchanged. After reset, blank_lvl is 00h.
- R9: The sample that carries s_sol is corrected with the level measured before it. When its s_bp flag is set, it is the first back-porch sample of the new line.
- R10: After reset, m_valid is low and s_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high together with s_valid |
| s_data | input | 8 | Digitized video sample |
| s_bp | input | 1 | Sample lies inside the back porch window |
| s_sol | input | 1 | Sample starts a new line; closes the previous measurement |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Corrected sample |
| std_pal | input | 1 | 0: 525-line targets, 1: 625-line targets |
| clamp_en | input | 1 | 1: apply correction, 0: pass through |
| tip_lvl | input | 4 | Sync tip code (before the standard offset) |
| blank_lvl | output | 8 | Measured blanking level |

## Verification
Directed lines with a flat back porch test the exact anchor, the default sync tip point in both standards, and the saturation at both ends of the code range. Together these separate the two blanking targets and the above- and below-blanking paths. A line with extra back-porch samples shows that only the first sixteen are counted, and a short line shows that the level is held. Random lines with noisy porches, random tip codes, toggled enable and standard, and a randomly stalling output test the averaging, the timing of the level update around the line-start sample, and data integrity under back-pressure.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  localparam logic [7:0] BLANK_525   = 8'h3C;
  localparam logic [7:0] BLANK_625   = 8'h40;
  localparam logic [3:0] TIP_OFS_625 = 4'd4;
  localparam int         SPAN_NOM    = 57;
endpackage

// File: rtl/bp_level_meter.sv
module bp_level_meter #(
  parameter int DW       = 8,
  parameter int AVG_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          bp,
  input  logic          sol,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] level
);
  localparam int CW = AVG_LOG2 + 1;
  localparam int AW = DW + AVG_LOG2;
  localparam logic [CW-1:0] NSAMP = CW'(1 << AVG_LOG2);

  logic [AW-1:0] acc;
  logic [CW-1:0] cnt;
  logic          full;

  assign full = (cnt == NSAMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      cnt   <= '0;
      level <= '0;
    end else if (take) begin
      if (sol) begin
        if (full) level <= acc[AW-1:AVG_LOG2];
        if (bp) begin
          acc <= AW'(din);
          cnt <= CW'(1);
        end else begin
          acc <= '0;
          cnt <= '0;
        end
      end else if (bp && !full) begin
        acc <= acc + AW'(din);
        cnt <= cnt + CW'(1);
      end
    end
  end

  // level moves only on an accepted line-start sample
  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && sol) |=> $stable(level));

  // never more than the averaging window is gathered
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NSAMP);
endmodule

// File: rtl/clamp_map.sv
module clamp_map #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] level,
  input  logic          en,
  input  logic          pal,
  input  logic [3:0]    tip,
  output logic [DW-1:0] dout
);
  import vbc_pkg::*;

  localparam int PW = 2 * DW;
  localparam logic [DW+1:0] MAXV = (DW+2)'((1 << DW) - 1);
  localparam logic [PW-1:0] SPAN = PW'(SPAN_NOM);

  logic [DW-1:0]   blank;
  logic [DW-1:0]   tipv;
  logic [DW+1:0]   up;
  logic [DW-1:0]   depth;
  logic [DW-1:0]   span;
  logic [PW-1:0]   prod;
  logic [PW-1:0]   quo;
  logic [DW-1:0]   clamped;

  always_comb begin
    blank   = pal ? DW'(BLANK_625) : DW'(BLANK_525);
    tipv    = DW'(tip) + (pal ? DW'(TIP_OFS_625) : '0);
    up      = (DW+2)'(din) + (DW+2)'(blank) - (DW+2)'(level);
    depth   = level - din;
    span    = blank - tipv;
    prod    = PW'(depth) * PW'(span);
    quo     = prod / SPAN;
    if (din >= level) begin
      clamped = (up > MAXV) ? MAXV[DW-1:0] : up[DW-1:0];
    end else begin
      clamped = (quo >= PW'(blank)) ? '0 : (blank - quo[DW-1:0]);
    end
    dout = en ? clamped : din;
  end

  // anchor: porch level lands on the target code
  always_comb begin
    if (en && (din == level)) begin
      p_anchor_r4: assert (dout == (pal ? DW'(BLANK_625) : DW'(BLANK_525)));
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // a stalled beat is held unchanged
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/vid_blank_clamp.sv
module vid_blank_clamp #(
  parameter int DW       = 8,
  parameter int AVG_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_bp,
  input  logic          s_sol,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  input  logic          std_pal,
  input  logic          clamp_en,
  input  logic [3:0]    tip_lvl,
  output logic [DW-1:0] blank_lvl
);
  logic          take;
  logic [DW-1:0] mapped;

  assign take = s_valid && s_ready;

  bp_level_meter #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_meter (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .bp    (s_bp),
    .sol   (s_sol),
    .din   (s_data),
    .level (blank_lvl)
  );

  clamp_map #(.DW(DW)) u_map (
    .din   (s_data),
    .level (blank_lvl),
    .en    (clamp_en),
    .pal   (std_pal),
    .tip   (tip_lvl),
    .dout  (mapped)
  );

  out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (mapped),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (m_data)
  );

  // bypass: accepted sample reappears untouched
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clamp_en) |=> (m_valid && m_data == $past(s_data)));
endmodule

// File: tb/tb_vid_blank_clamp.sv
module tb_vid_blank_clamp;
  localparam int CLK_PERIOD = 10;
  localparam int NAVG = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       s_bp = 1'b0;
  logic       s_sol = 1'b0;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic [7:0] m_data;
  logic       std_pal = 1'b0;
  logic       clamp_en = 1'b1;
  logic [3:0] tip_lvl = 4'd3;
  logic [7:0] blank_lvl;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int tag_q[$];
  int mL = 0, macc = 0, mcnt = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_blank_clamp dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_bp(s_bp), .s_sol(s_sol), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .std_pal(std_pal),
    .clamp_en(clamp_en), .tip_lvl(tip_lvl), .blank_lvl(blank_lvl)
  );

  function automatic string tname(int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic int model_out(int d, int lv, bit en, bit pal, int tip);
    int b, t, q, r;
    b = pal ? 64 : 60;
    t = tip + (pal ? 4 : 0);
    if (!en) return d;
    if (d >= lv) begin
      r = d - lv + b;
      return (r > 255) ? 255 : r;
    end
    q = ((lv - d) * (b - t)) / 57;
    r = b - q;
    return (r < 0) ? 0 : r;
  endfunction

  function automatic int tag_of(int d, int lv, bit en, bit sol, int tip);
    if (sol) return 9;
    if (!en) return 2;
    if (d == lv) return 4;
    if (d > lv) return 3;
    if (tip == 3 && lv - d == 57) return 6;
    return 5;
  endfunction

  task automatic chk(bit ok, int tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tname(tag), act, expv);
    end
  endtask

  // monitor: sample between edges, before the next posedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) chk(1'b0, 1, int'(m_data), -1);
        else begin
          int e, t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(int'(m_data) == e, t, int'(m_data), e);
        end
      end
      if (m_valid && !m_ready) chk(s_ready == 1'b0, 1, int'(s_ready), 0);
      if (s_valid && s_ready) begin
        exp_q.push_back(model_out(int'(s_data), mL, clamp_en, std_pal, int'(tip_lvl)));
        tag_q.push_back(tag_of(int'(s_data), mL, clamp_en, s_sol, int'(tip_lvl)));
        if (s_sol) begin
          chk(int'(blank_lvl) == mL, 7, int'(blank_lvl), mL);
          if (mcnt == NAVG) mL = macc / NAVG;
          macc = 0; mcnt = 0;
        end
        if (s_bp && mcnt < NAVG) begin
          macc += int'(s_data);
          mcnt++;
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_ready) m_ready = ($urandom % 4) != 0;
  end

  // caller sits just after a posedge
  task automatic send(int d, bit bp, bit sol);
    s_valid = 1'b1; s_data = 8'(d); s_bp = bp; s_sol = sol;
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #1;
    s_valid = 1'b0; s_bp = 1'b0; s_sol = 1'b0;
  endtask

  task automatic flat_line(int lv, int nbp, int extra_val, int nextra);
    send(0, 1'b0, 1'b1);
    for (int i = 0; i < nbp; i++) send(lv, 1'b1, 1'b0);
    for (int i = 0; i < nextra; i++) send(extra_val, 1'b1, 1'b0);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0) && n < 1000) begin
      @(posedge clk); #1; n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(m_valid == 1'b0, 10, int'(m_valid), 0);
    chk(s_ready == 1'b1, 10, int'(s_ready), 1);
    chk(blank_lvl == 8'h00, 8, int'(blank_lvl), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R7: level 50h, extra porch samples of 00h must be ignored
    std_pal = 1'b0; clamp_en = 1'b1; tip_lvl = 4'd3;
    flat_line(8'h50, 16, 0, 4);
    send(8'h50, 1'b0, 1'b1);
    chk(blank_lvl == 8'h50, 7, int'(blank_lvl), 8'h50);
    // R4, R6, R3 saturation, R5 floor at zero
    send(8'h50, 1'b0, 1'b0);
    send(8'h50 - 57, 1'b0, 1'b0);
    send(8'hFF, 1'b0, 1'b0);
    send(8'h00, 1'b0, 1'b0);
    send(8'h60, 1'b0, 1'b0);
    // same in the 625-line mode
    std_pal = 1'b1;
    send(8'h50, 1'b0, 1'b0);
    send(8'h50 - 57, 1'b0, 1'b0);
    send(8'hFF, 1'b0, 1'b0);
    send(8'hC0, 1'b0, 1'b0);
    // R8: short line holds the level
    std_pal = 1'b0;
    flat_line(8'h90, 5, 0, 0);
    send(8'h20, 1'b0, 1'b1);
    chk(blank_lvl == 8'h50, 8, int'(blank_lvl), 8'h50);
    // R2: bypass
    clamp_en = 1'b0;
    send(8'h11, 1'b0, 1'b0);
    send(8'hEE, 1'b0, 1'b0);
    clamp_en = 1'b1;
    drain();

    // random lines with back-pressure
    rand_ready = 1'b1;
    for (int ln = 0; ln < 60; ln++) begin
      int lv, nbp;
      std_pal  = $urandom % 2;
      clamp_en = ($urandom % 5) != 0;
      tip_lvl  = 4'($urandom % 16);
      lv  = 40 + $urandom % 160;
      nbp = (($urandom % 5) == 0) ? ($urandom % 16) : (16 + $urandom % 4);
      send($urandom % 256, ($urandom % 2) == 1, 1'b1);
      for (int i = 0; i < nbp; i++) send(lv - 3 + $urandom % 7, 1'b1, 1'b0);
      for (int i = 0; i < 24; i++) send($urandom % 256, 1'b0, 1'b0);
    end
    rand_ready = 1'b0;
    @(posedge clk); #1;
    m_ready = 1'b1;
    drain();
    chk(exp_q.size() == 0, 1, exp_q.size(), 0);
    chk(int'(blank_lvl) == mL, 7, int'(blank_lvl), mL);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule